// File: doc/BRIEF.md
# Double-Buffered USB OUT Endpoint Receiver

This block is the receive half of a USB device OUT endpoint. It has two payload banks that take turns. A packet-level front end delivers each decoded OUT transaction as a sequence of signals: a start pulse for the token and data, one strobe per payload byte, and an end-of-packet marker that reports whether the CRC was good. The block writes the payload into the bank whose turn it is. One cycle after the end marker it reports a handshake decision of ACK, NAK or STALL.

On the processor side, each bank has a full flag that only the processor clears, a byte count and an asynchronous read port. While the processor drains one bank, the host can fill the other. The interrupt line is high while either bank holds unread data. When both flags are set, the block does not record which bank was filled first, so the processor must track that order itself. A level-sensitive force-stall input makes the endpoint refuse every transaction with STALL for as long as it is held.

Top module: `ep_out_pingpong`

## Requirements
- R1: After reset, both full flags are clear, `irq` is low, `hs_vld` is low, both counts read 0, and bank 0 takes the first payload.
- R2: Accepted payloads go to bank 0, bank 1, bank 0 and so on in turn. Only an accepted payload moves the turn to the other bank.
- R3: A payload with a good CRC and at most `BANK_BYTES` bytes, whose target bank is empty and with force-stall low at its start, is stored from address 0 upward. That bank's full flag is set, and `hs_vld` pulses high for one cycle, in the cycle after the end marker, with `hs_code` = 2'b01 (ACK).
- R4: A full flag stays set until a clear strobe for that bank. The flag reads low in the cycle after the clock edge that samples the strobe.
- R5: If the target bank is still full when the packet starts, the block answers with `hs_code` = 2'b10 (NAK). It writes nothing, leaves both flags as they were, and keeps the same target bank.
- R6: While one bank is full, the other bank can accept a payload, so both flags can be set at once.
- R7: `irq` is high exactly when at least one full flag is set.
- R8: If `force_stall` is high when a packet starts, the block answers with `hs_code` = 2'b11 (STALL), even where ACK or NAK would apply, and sets no flag. Once `force_stall` is low again, normal answers resume.
- R9: A packet whose end marker reports a bad CRC gets no handshake, and both the flags and the target bank stay as they were.
- R10: A payload of more than `BANK_BYTES` bytes gets no handshake and sets no flag. A payload of exactly `BANK_BYTES` bytes is accepted.
- R11: A bank's count port shows the number of accepted bytes while that bank's flag is set, and reads 0 while the flag is clear.
- R12: A clear strobe for a bank whose flag is clear changes neither flag, nor the counts, nor the target bank.
- R13: A zero-length payload with a good CRC is accepted with ACK, and that bank's count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle pulse that opens an OUT transaction |
| pkt_dat_vld | input | 1 | Payload byte strobe |
| pkt_dat | input | 8 | Payload byte |
| pkt_eop | input | 1 | End-of-packet marker; must fall in a cycle of its own, with no byte strobe |
| pkt_crc_ok | input | 1 | Good-CRC indication, sampled with `pkt_eop` |
| hs_vld | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| force_stall | input | 1 | Refuse all transactions with STALL while high |
| bank_clr | input | 2 | Per-bank clear strobes for the full flags |
| bank_full | output | 2 | Per-bank full flags |
| bank0_count | output | $clog2(BANK_BYTES+1) | Bytes held in bank 0 |
| bank1_count | output | $clog2(BANK_BYTES+1) | Bytes held in bank 1 |
| bank0_rd_addr | input | $clog2(BANK_BYTES) | Read address into bank 0 |
| bank0_rd_data | output | 8 | Read data from bank 0 |
| bank1_rd_addr | input | $clog2(BANK_BYTES) | Read address into bank 1 |
| bank1_rd_data | output | 8 | Read data from bank 1 |
| irq | output | 1 | High while either bank is full |

## Verification
The bench builds the block with `BANK_BYTES` = 8. With that value, a nine-byte packet overflows the bank and an eight-byte packet fills it exactly, so the size boundary is reached with short packets. The smaller depth also makes it cheap to drive long ordered runs that fill both banks, draw NAK on the held bank, and then resume after out-of-order clears. Those runs expose a turn pointer that wrongly moves after a refused or corrupted packet. Stall priority is checked both against a payload that would have drawn NAK and against one that would have drawn ACK.

// File: rtl/usbo_pkg.sv
package usbo_pkg;

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BYTE_W    = 8;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FILL,
        RX_NAK,
        RX_STALL
    } rx_mode_e;

    typedef struct packed {
        logic              start;
        logic              dat_vld;
        logic [BYTE_W-1:0] dat;
        logic              eop;
        logic              crc_ok;
    } pkt_in_t;

    typedef struct packed {
        logic     vld;
        hs_code_e code;
    } hs_t;

    function automatic hs_code_e mode_to_hs(input rx_mode_e m);
        case (m)
            RX_FILL:  return HS_ACK;
            RX_NAK:   return HS_NAK;
            RX_STALL: return HS_STALL;
            default:  return HS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ep_rx_ctrl.sv
module ep_rx_ctrl
    import usbo_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned AW = $clog2(BANK_BYTES),
    localparam int unsigned CW = $clog2(BANK_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  pkt_in_t                   pkt,
    input  logic                      force_stall,
    input  logic [NUM_BANKS-1:0]      bank_full,
    output logic                      wr_en,
    output logic                      tgt_bank,
    output logic [AW-1:0]             wr_addr,
    output logic [BYTE_W-1:0]         wr_data,
    output logic                      fill_done,
    output logic [CW-1:0]             fill_count,
    output hs_t                       hs
);

    localparam logic [CW-1:0] LIMIT = CW'(BANK_BYTES);

    rx_mode_e     mode;
    logic         ptr;
    logic [CW-1:0] cnt;
    logic         ovf;
    logic         room;
    logic         in_pkt;
    logic         good_end;

    assign in_pkt   = (mode != RX_IDLE) && !pkt.start;
    assign room     = (cnt != LIMIT);
    assign good_end = in_pkt && pkt.eop && pkt.crc_ok && !ovf;

    // Byte write path into the bank selected by the turn pointer
    assign wr_en      = in_pkt && (mode == RX_FILL) && pkt.dat_vld && !pkt.eop && room;
    assign tgt_bank   = ptr;
    assign wr_addr    = cnt[AW-1:0];
    assign wr_data    = pkt.dat;
    assign fill_done  = good_end && (mode == RX_FILL);
    assign fill_count = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= RX_IDLE;
            ptr  <= 1'b0;
            cnt  <= '0;
            ovf  <= 1'b0;
            hs   <= '{vld: 1'b0, code: HS_NONE};
        end else begin
            hs <= '{vld: 1'b0, code: HS_NONE};
            if (pkt.start) begin
                cnt <= '0;
                ovf <= 1'b0;
                if (force_stall)
                    mode <= RX_STALL;
                else if (bank_full[ptr])
                    mode <= RX_NAK;
                else
                    mode <= RX_FILL;
            end else if (mode != RX_IDLE) begin
                if (pkt.eop) begin
                    mode <= RX_IDLE;
                    if (good_end) begin
                        hs <= '{vld: 1'b1, code: mode_to_hs(mode)};
                        if (mode == RX_FILL)
                            ptr <= ~ptr;
                    end
                end else if (pkt.dat_vld) begin
                    if (room)
                        cnt <= cnt + 1'b1;
                    else
                        ovf <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ep_bank_store.sv
module ep_bank_store
    import usbo_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned AW = $clog2(BANK_BYTES),
    localparam int unsigned CW = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              fill_done,
    input  logic [CW-1:0]     fill_count,
    input  logic              clr,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              full,
    output logic [CW-1:0]     count
);

    logic [BYTE_W-1:0] mem [BANK_BYTES];
    logic [CW-1:0]     held;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (fill_done) begin
            full <= 1'b1;
            held <= fill_count;
        end else if (clr) begin
            full <= 1'b0;
        end
    end

    assign count   = full ? held : '0;
    assign rd_data = (32'(rd_addr) < BANK_BYTES) ? mem[rd_addr] : '0;

endmodule

// File: rtl/ep_out_pingpong.sv
module ep_out_pingpong
    import usbo_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned AW = $clog2(BANK_BYTES),
    localparam int unsigned CW = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_start,
    input  logic              pkt_dat_vld,
    input  logic [7:0]        pkt_dat,
    input  logic              pkt_eop,
    input  logic              pkt_crc_ok,
    output logic              hs_vld,
    output logic [1:0]        hs_code,
    input  logic              force_stall,
    input  logic [1:0]        bank_clr,
    output logic [1:0]        bank_full,
    output logic [CW-1:0]     bank0_count,
    output logic [CW-1:0]     bank1_count,
    input  logic [AW-1:0]     bank0_rd_addr,
    output logic [7:0]        bank0_rd_data,
    input  logic [AW-1:0]     bank1_rd_addr,
    output logic [7:0]        bank1_rd_data,
    output logic              irq
);

    pkt_in_t            pkt;
    hs_t                hs;
    logic               c_wr_en;
    logic               c_bank;
    logic [AW-1:0]      c_wr_addr;
    logic [BYTE_W-1:0]  c_wr_data;
    logic               c_fill_done;
    logic [CW-1:0]      c_fill_count;
    logic [NUM_BANKS-1:0] flags;

    logic [AW-1:0]     rd_addr_a [NUM_BANKS];
    logic [BYTE_W-1:0] rd_data_a [NUM_BANKS];
    logic [CW-1:0]     cnt_a     [NUM_BANKS];

    assign pkt = '{start: pkt_start, dat_vld: pkt_dat_vld, dat: pkt_dat,
                   eop: pkt_eop, crc_ok: pkt_crc_ok};

    ep_rx_ctrl #(.BANK_BYTES(BANK_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pkt        (pkt),
        .force_stall(force_stall),
        .bank_full  (flags),
        .wr_en      (c_wr_en),
        .tgt_bank   (c_bank),
        .wr_addr    (c_wr_addr),
        .wr_data    (c_wr_data),
        .fill_done  (c_fill_done),
        .fill_count (c_fill_count),
        .hs         (hs)
    );

    assign rd_addr_a[0] = bank0_rd_addr;
    assign rd_addr_a[1] = bank1_rd_addr;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (c_bank == 1'(b));
        ep_bank_store #(.BANK_BYTES(BANK_BYTES)) u_store (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (c_wr_en && sel),
            .wr_addr   (c_wr_addr),
            .wr_data   (c_wr_data),
            .fill_done (c_fill_done && sel),
            .fill_count(c_fill_count),
            .clr       (bank_clr[b]),
            .rd_addr   (rd_addr_a[b]),
            .rd_data   (rd_data_a[b]),
            .full      (flags[b]),
            .count     (cnt_a[b])
        );
    end

    assign bank0_rd_data = rd_data_a[0];
    assign bank1_rd_data = rd_data_a[1];
    assign bank0_count   = cnt_a[0];
    assign bank1_count   = cnt_a[1];
    assign bank_full     = flags;
    assign irq           = |flags;
    assign hs_vld        = hs.vld;
    assign hs_code       = hs.code;

endmodule

// File: rtl/ep_out_pingpong_chk.sv
module ep_out_pingpong_chk (
    input logic       clk,
    input logic       rst,
    input logic       hs_vld,
    input logic [1:0] hs_code,
    input logic [1:0] bank_full,
    input logic [1:0] bank_clr
);

    assert_hs_code_valid_R3: assert property (@(posedge clk) disable iff (rst)
        hs_vld |-> hs_code != 2'b00);

    assert_ack_adds_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (hs_vld && hs_code == 2'b01 && $past(bank_clr) == 2'b00)
        |-> $countones(bank_full) == $countones($past(bank_full)) + 1);

    assert_rise0_needs_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_full[0]) |-> (hs_vld && hs_code == 2'b01));

    assert_rise1_needs_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_full[1]) |-> (hs_vld && hs_code == 2'b01));

    assert_clear0_next_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $past(bank_clr[0] && bank_full[0]) |-> !bank_full[0]);

    assert_clear1_next_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $past(bank_clr[1] && bank_full[1]) |-> !bank_full[1]);

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!hs_vld && $past(bank_clr) == 2'b00) |-> $stable(bank_full));

    assert_nak_no_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (hs_vld && hs_code == 2'b10)
        |-> $countones(bank_full) <= $countones($past(bank_full)));

    assert_stall_no_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_vld && hs_code == 2'b11)
        |-> $countones(bank_full) <= $countones($past(bank_full)));

endmodule

bind ep_out_pingpong ep_out_pingpong_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .hs_vld   (hs_vld),
    .hs_code  (hs_code),
    .bank_full(bank_full),
    .bank_clr (bank_clr)
);

// File: tb/tb_ep_out_pingpong.sv
module tb_ep_out_pingpong;

    localparam int unsigned BB = 8;
    localparam int unsigned AW = $clog2(BB);
    localparam int unsigned CW = $clog2(BB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_start = 1'b0, pkt_dat_vld = 1'b0, pkt_eop = 1'b0, pkt_crc_ok = 1'b0;
    logic [7:0]    pkt_dat = '0;
    logic          hs_vld;
    logic [1:0]    hs_code;
    logic          force_stall = 1'b0;
    logic [1:0]    bank_clr = '0;
    logic [1:0]    bank_full;
    logic [CW-1:0] bank0_count, bank1_count;
    logic [AW-1:0] bank0_rd_addr = '0, bank1_rd_addr = '0;
    logic [7:0]    bank0_rd_data, bank1_rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ep_out_pingpong #(.BANK_BYTES(BB)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base, input bit crc,
                            output logic [1:0] code);
        @(negedge clk) pkt_start = 1'b1;
        @(negedge clk) pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pkt_dat_vld = 1'b1;
            pkt_dat     = 8'(base + i);
            @(negedge clk);
        end
        pkt_dat_vld = 1'b0;
        pkt_eop     = 1'b1;
        pkt_crc_ok  = crc;
        @(negedge clk);
        pkt_eop    = 1'b0;
        pkt_crc_ok = 1'b0;
        code = hs_vld ? hs_code : 2'b00;
    endtask

    task automatic clr_banks(input logic [1:0] mask);
        @(negedge clk) bank_clr = mask;
        @(negedge clk) bank_clr = 2'b00;
    endtask

    task automatic rd0(input int a, output int d);
        bank0_rd_addr = AW'(a);
        #1 d = int'(bank0_rd_data);
    endtask

    task automatic rd1(input int a, output int d);
        bank1_rd_addr = AW'(a);
        #1 d = int'(bank1_rd_data);
    endtask

    task automatic t_reset();
        chk(bank_full == 2'b00, "R1", "flags after reset", bank_full, 0);
        chk(!irq, "R1", "irq after reset", irq, 0);
        chk(!hs_vld, "R1", "hs_vld after reset", hs_vld, 0);
        chk(bank0_count == 0 && bank1_count == 0, "R1", "counts after reset",
            bank0_count + bank1_count, 0);
    endtask

    task automatic t_alternate();
        logic [1:0] c;
        int d;
        send_pkt(3, 8'h10, 1'b1, c);
        chk(c == 2'b01, "R3", "first payload handshake", c, 1);
        chk(bank_full == 2'b01, "R2", "first payload lands in bank 0", bank_full, 1);
        chk(bank0_count == 3, "R11", "bank 0 count", bank0_count, 3);
        rd0(2, d);
        chk(d == 8'h12, "R3", "bank 0 byte 2", d, 8'h12);
        chk(irq, "R7", "irq with bank 0 full", irq, 1);
        send_pkt(5, 8'h40, 1'b1, c);
        chk(c == 2'b01, "R6", "second payload while bank 0 full", c, 1);
        chk(bank_full == 2'b11, "R6", "both flags set", bank_full, 3);
        chk(bank1_count == 5, "R11", "bank 1 count", bank1_count, 5);
        rd1(4, d);
        chk(d == 8'h44, "R2", "bank 1 byte 4", d, 8'h44);
        rd0(0, d);
        chk(d == 8'h10, "R2", "bank 0 untouched by second payload", d, 8'h10);
    endtask

    task automatic t_nak();
        logic [1:0] c;
        int d;
        send_pkt(2, 8'h70, 1'b1, c);
        chk(c == 2'b10, "R5", "both full gives NAK", c, 2);
        chk(bank_full == 2'b11 && bank0_count == 3 && bank1_count == 5, "R5",
            "NAK leaves state", bank_full, 3);
        rd0(0, d);
        chk(d == 8'h10, "R5", "NAK payload not written", d, 8'h10);
        clr_banks(2'b10);
        chk(bank_full == 2'b01, "R4", "bank 1 clear next edge", bank_full, 1);
        chk(bank1_count == 0, "R11", "cleared bank count reads 0", bank1_count, 0);
        send_pkt(2, 8'h80, 1'b1, c);
        chk(c == 2'b10, "R5", "target bank 0 still full", c, 2);
        clr_banks(2'b01);
        chk(bank_full == 2'b00 && !irq, "R7", "irq low with no flag", irq, 0);
        send_pkt(2, 8'hA0, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b01, "R5", "turn held after NAK", bank_full, 1);
        rd0(0, d);
        chk(d == 8'hA0, "R5", "resumed payload in bank 0", d, 8'hA0);
    endtask

    task automatic t_clear_unset();
        logic [1:0] c;
        clr_banks(2'b10);
        chk(bank_full == 2'b01 && bank0_count == 2, "R12", "clear of empty bank ignored",
            bank_full, 1);
        send_pkt(1, 8'h55, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b11, "R12", "turn unchanged by stray clear",
            bank_full, 3);
        clr_banks(2'b11);
        chk(bank_full == 2'b00, "R4", "clear both", bank_full, 0);
    endtask

    task automatic t_badcrc();
        logic [1:0] c;
        send_pkt(4, 8'h20, 1'b0, c);
        chk(c == 2'b00, "R9", "bad CRC no handshake", c, 0);
        chk(bank_full == 2'b00, "R9", "bad CRC no flag", bank_full, 0);
        send_pkt(2, 8'h30, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b01, "R9", "turn held after bad CRC",
            bank_full, 1);
        clr_banks(2'b01);
    endtask

    task automatic t_oversize();
        logic [1:0] c;
        int d;
        send_pkt(BB + 1, 8'h00, 1'b1, c);
        chk(c == 2'b00 && bank_full == 2'b00, "R10", "oversize dropped", c, 0);
        send_pkt(BB, 8'hC0, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b10, "R10", "exact size accepted", bank_full, 2);
        chk(bank1_count == BB, "R10", "exact size count", bank1_count, BB);
        rd1(BB - 1, d);
        chk(d == 8'hC0 + BB - 1, "R10", "last byte", d, 8'hC0 + BB - 1);
        clr_banks(2'b10);
    endtask

    task automatic t_zero_and_stall();
        logic [1:0] c;
        send_pkt(0, 8'h00, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b01, "R13", "zero length accepted", bank_full, 1);
        chk(bank0_count == 0, "R13", "zero length count", bank0_count, 0);
        send_pkt(1, 8'h66, 1'b1, c);
        chk(bank_full == 2'b11, "R6", "fill bank 1", bank_full, 3);
        force_stall = 1'b1;
        send_pkt(2, 8'h11, 1'b1, c);
        chk(c == 2'b11, "R8", "stall over NAK", c, 3);
        chk(bank_full == 2'b11, "R8", "stall keeps flags", bank_full, 3);
        clr_banks(2'b01);
        send_pkt(2, 8'h12, 1'b1, c);
        chk(c == 2'b11 && bank_full == 2'b10, "R8", "stall over ACK", c, 3);
        force_stall = 1'b0;
        send_pkt(2, 8'h13, 1'b1, c);
        chk(c == 2'b01 && bank_full == 2'b11, "R8", "normal after stall release", c, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_alternate();
        t_nak();
        t_clear_unset();
        t_badcrc();
        t_oversize();
        t_zero_and_stall();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule